// File: doc/BRIEF.md
# Host Mailbox Interrupt Controller

This block sits on the device side of a byte-wide host port and lets the host CPU take event interrupts. Internal logic offers status bytes on an event input. Once the host has armed and enabled the mailbox, each accepted byte raises the active-high interrupt line. The host services the interrupt through one control offset and gets back the byte that caused it.

Arming is a two-byte handshake. The host writes 0x02 and then 0x04 to the control offset. Enabling and acknowledging use the same pair of accesses: a write of 0x06 followed by a read of the control offset. The read returns the oldest pending event code, or 0x00 if no event is pending. The first such pair after arming turns event capture on. The queue holds the event being serviced plus one more. Events beyond that are lost and set a sticky overflow flag. A FIFO-clear pulse wipes the arming, the enable, the pending events and the flag, so the host must arm and enable again.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, irq and evt_overflow are low, host_rdata is 0x00 and the block is unarmed. In that state a 0x06 write, a read and then an event leave irq low.
- R2: The block becomes armed by a write of 0x02 and then a write of 0x04, both at the control offset, with no other control write between them. A 0x04 write not directly preceded by 0x02 does not arm the block.
- R3: Any control write other than 0x04 that directly follows a 0x02 abandons the arming sequence. This includes 0x02 itself. A later 0x04 then has no effect.
- R4: When the block is armed, a 0x06 write followed by a control read enables event capture. That read returns 0x00 when nothing is pending. Events offered before the block is enabled are discarded and raise no interrupt.
- R5: While the block is armed and enabled, an event sampled with evt_valid high at a clock edge drives irq high right after that edge.
- R6: A 0x06 write followed by a control read returns the oldest pending event code on host_rdata right after the read edge, removes that event, and drops irq when no other event is pending.
- R7: A second event that arrives while one is pending is held. After the first acknowledge irq stays high, and the next acknowledge returns the second code. Events are returned oldest first.
- R8: An event that arrives while two are held is discarded and sets evt_overflow. The flag stays set through later acknowledges until a FIFO clear.
- R9: A control read that does not directly follow a 0x06 write returns 0x00 and leaves irq and the pending events unchanged. Any control write other than 0x06 between the 0x06 write and the read cancels the acknowledge.
- R10: A fifo_clr pulse drops irq, evt_overflow, the pending events, the enable and the arming. The block ignores events until it has been armed and enabled again.
- R11: Reads and writes at any offset other than the control offset (1) have no effect on arming, enable, acknowledge or irq.
- R12: If an acknowledge read and a new event arrive in the same cycle, the read returns the old head and the new event is queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Host register offset; 1 is the control offset |
| host_wr_en | input | 1 | Host write strobe, one cycle per access |
| host_rd_en | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned by the last control read |
| evt_valid | input | 1 | Event offered this cycle |
| evt_code | input | 8 | Event designator byte |
| fifo_clr | input | 1 | Clears the interrupt configuration and pending events |
| irq | output | 1 | Interrupt request, active high |
| evt_overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The bench sweeps every first byte ahead of a 0x04 write, and every byte placed between 0x02 and 0x04. A design that armed on a lone 0x04, or that restarted on a repeated 0x02, would show irq in the wrong pattern. It sends all 256 event codes through the acknowledge path, so a mangled or stale return byte shows up at once. The directed cases target the points where a design most easily goes wrong. A design with no pending slot would lose the second event. A design whose overflow flag clears on acknowledge would fail the sticky check. Other cases are a read with no 0x06 in front of it, or with a stray write in between, which a loose design would treat as an acknowledge. The last cases are an acknowledge that meets a new event in the same cycle, and a FIFO clear that must leave the block deaf until it is armed and enabled again.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CMD_ARM_FIRST  = 8'h02;
    localparam byte_t CMD_ARM_SECOND = 8'h04;
    localparam byte_t CMD_ACK        = 8'h06;

    typedef enum logic {
        ARM_IDLE,
        ARM_HALF
    } arm_st_e;

endpackage

// File: rtl/mbx_arm_seq.sv
module mbx_arm_seq
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  wr_stb,
    input  byte_t wdata,
    output logic  configured
);

    typedef struct packed {
        arm_st_e st;
        logic    cfg;
    } arm_t;

    arm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.st  = ARM_IDLE;
            s_d.cfg = 1'b0;
        end else if (wr_stb) begin
            case (s_q.st)
                ARM_IDLE: begin
                    if (wdata == CMD_ARM_FIRST) s_d.st = ARM_HALF;
                end
                ARM_HALF: begin
                    s_d.st = ARM_IDLE;
                    if (wdata == CMD_ARM_SECOND) s_d.cfg = 1'b1;
                end
                default: s_d.st = ARM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ARM_IDLE, cfg: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign configured = s_q.cfg;

    // R2: arming only ever completes on a second-byte write from the half state
    a_r2_cfg_needs_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cfg) |-> $past(wr_stb && wdata == CMD_ARM_SECOND && s_q.st == ARM_HALF));

endmodule

// File: rtl/mbx_evt_queue.sv
module mbx_evt_queue
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  push,
    input  byte_t push_code,
    input  logic  pop,
    output logic  head_valid,
    output byte_t head_code,
    output logic  overflow
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        byte_t [DEPTH-1:0] slot;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
    } q_t;

    q_t   s_d, s_q;
    logic drained;

    always_comb begin
        s_d     = s_q;
        drained = pop && (s_q.cnt != '0);
        if (drained) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                s_d.slot[i] = s_q.slot[i+1];
            end
            s_d.cnt = s_q.cnt - 1'b1;
        end
        if (push) begin
            if (s_d.cnt < FULL) begin
                for (int i = 0; i < int'(DEPTH); i++) begin
                    if (CNT_W'(i) == s_d.cnt) s_d.slot[i] = push_code;
                end
                s_d.cnt = s_d.cnt + 1'b1;
            end else begin
                s_d.ovf = 1'b1;
            end
        end
        if (clr) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_valid = (s_q.cnt != '0);
    assign head_code  = s_q.slot[0];
    assign overflow   = s_q.ovf;

    // R7: a pop with no push removes exactly one entry
    a_r7_pop_drains_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && s_q.cnt != '0) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R8: a push into a full queue with no pop raises the flag
    a_r8_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && s_q.cnt == FULL) |=> overflow);

    // R8: the flag holds until a clear
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow);

endmodule

// File: rtl/mbx_host_port.sv
module mbx_host_port
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  wr_stb,
    input  logic  rd_stb,
    input  byte_t wdata,
    input  logic  configured,
    input  logic  head_valid,
    input  byte_t head_code,
    output logic  ack_pop,
    output logic  enabled,
    output byte_t rdata
);

    typedef struct packed {
        logic  ack_armed;
        logic  en;
        byte_t rd;
    } port_t;

    port_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        ack_pop = rd_stb && s_q.ack_armed && !clr;
        if (wr_stb) begin
            s_d.ack_armed = (wdata == CMD_ACK);
        end
        if (rd_stb) begin
            s_d.ack_armed = 1'b0;
            if (s_q.ack_armed) begin
                s_d.rd = head_valid ? head_code : '0;
                s_d.en = s_q.en || configured;
            end else begin
                s_d.rd = '0;
            end
        end
        if (clr) begin
            s_d.ack_armed = 1'b0;
            s_d.en        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign enabled = s_q.en;
    assign rdata   = s_q.rd;

    // R4: capture is never enabled without arming
    a_r4_enable_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> configured);

    // R9: a read that is not part of an acknowledge returns zero
    a_r9_plain_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !s_q.ack_armed) |=> (rdata == '0));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned CTRL_OFS = 1,
    parameter int unsigned Q_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr_en,
    input  logic              host_rd_en,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              evt_valid,
    input  logic [7:0]        evt_code,
    input  logic              fifo_clr,
    output logic              irq,
    output logic              evt_overflow
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

    logic  ctrl_hit, wr_stb, rd_stb;
    logic  configured, enabled, ack_pop, head_valid, push;
    byte_t head_code;

    assign ctrl_hit = (host_addr == CTRL_ADDR);
    assign wr_stb   = host_wr_en && ctrl_hit;
    assign rd_stb   = host_rd_en && !host_wr_en && ctrl_hit;
    assign push     = evt_valid && configured && enabled && !fifo_clr;

    mbx_arm_seq u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .wr_stb     (wr_stb),
        .wdata      (host_wdata),
        .configured (configured)
    );

    mbx_host_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .wdata      (host_wdata),
        .configured (configured),
        .head_valid (head_valid),
        .head_code  (head_code),
        .ack_pop    (ack_pop),
        .enabled    (enabled),
        .rdata      (host_rdata)
    );

    mbx_evt_queue #(.DEPTH(Q_DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fifo_clr),
        .push       (push),
        .push_code  (evt_code),
        .pop        (ack_pop),
        .head_valid (head_valid),
        .head_code  (head_code),
        .overflow   (evt_overflow)
    );

    assign irq = configured && enabled && head_valid;

    // R5: an accepted event raises irq on the next cycle
    a_r5_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && configured && enabled && !fifo_clr) |=> irq);

    // R10: a clear quiets irq and the overflow flag
    a_r10_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (!irq && !evt_overflow));

endmodule

// File: tb/test_mbx_irq_ctrl.sv
module test_mbx_irq_ctrl;

    localparam logic [1:0] CTRL  = 2'd1;
    localparam logic [1:0] OTHER = 2'd0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic       host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       evt_valid = 1'b0;
    logic [7:0] evt_code = '0;
    logic       fifo_clr = 1'b0;
    logic       irq, evt_overflow;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    mbx_irq_ctrl i_mbx_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_valid(evt_valid), .evt_code(evt_code),
        .fifo_clr(fifo_clr), .irq(irq), .evt_overflow(evt_overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd_en = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic evt(input logic [7:0] c);
        @(negedge clk);
        evt_valid = 1'b1; evt_code = c;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic ack(output logic [7:0] d);
        wr(CTRL, 8'h06);
        rd(CTRL, d);
    endtask

    task automatic arm();
        wr(CTRL, 8'h02);
        wr(CTRL, 8'h04);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 ovf", evt_overflow, 0);
        check("R1 rdata", host_rdata, 0);
        ack(rv);
        evt(8'h05);
        check("R1 unarmed irq", irq, 0);

        // R2 sweep of the byte ahead of 0x04
        for (int x = 0; x < 256; x++) begin
            clr();
            wr(CTRL, 8'(x));
            wr(CTRL, 8'h04);
            ack(rv);
            evt(8'h01);
            check("R2 arm order", irq, (x == 2) ? 1 : 0);
        end

        // R3 sweep of the byte between 0x02 and 0x04
        for (int y = 0; y < 256; y++) begin
            clr();
            wr(CTRL, 8'h02);
            wr(CTRL, 8'(y));
            wr(CTRL, 8'h04);
            ack(rv);
            evt(8'h01);
            check("R3 abort", irq, (y == 4) ? 1 : 0);
        end

        // R11 other offset ignored
        clr();
        wr(CTRL, 8'h02);
        wr(OTHER, 8'h07);
        wr(CTRL, 8'h04);
        wr(OTHER, 8'h06);
        rd(CTRL, rv);
        evt(8'h21);
        check("R11 no enable via other offset", irq, 0);
        ack(rv);
        evt(8'h21);
        check("R11 armed despite other write", irq, 1);
        wr(OTHER, 8'h06);
        rd(CTRL, rv);
        check("R11 ack via other offset ignored rdata", rv, 0);
        check("R11 ack via other offset ignored irq", irq, 1);

        // R4 enable read and early events dropped
        clr();
        arm();
        evt(8'h09);
        check("R4 event before enable", irq, 0);
        ack(rv);
        check("R4 enable read value", rv, 0);
        check("R4 dropped event stays dropped", irq, 0);

        // R5 / R6 sweep all codes through acknowledge
        for (int c = 0; c < 256; c++) begin
            evt(8'(c));
            check("R5 irq after event", irq, 1);
            ack(rv);
            check("R6 ack code", rv, c);
            check("R6 irq cleared", irq, 0);
        end

        // R7 one pending slot, oldest first
        evt(8'h11);
        evt(8'h22);
        ack(rv);
        check("R7 first code", rv, 8'h11);
        check("R7 irq held", irq, 1);
        ack(rv);
        check("R7 second code", rv, 8'h22);
        check("R7 irq drop", irq, 0);
        check("R7 no overflow", evt_overflow, 0);

        // R8 overflow sticky
        evt(8'hA1);
        evt(8'hA2);
        check("R8 no ovf yet", evt_overflow, 0);
        evt(8'hA3);
        check("R8 ovf set", evt_overflow, 1);
        ack(rv);
        check("R8 first kept", rv, 8'hA1);
        ack(rv);
        check("R8 second kept", rv, 8'hA2);
        check("R8 third dropped", irq, 0);
        check("R8 ovf sticky", evt_overflow, 1);
        ack(rv);
        check("R8 empty read", rv, 0);

        // R9 plain reads and cancelled acknowledge
        clr();
        arm();
        ack(rv);
        evt(8'h33);
        rd(CTRL, rv);
        check("R9 plain read value", rv, 0);
        check("R9 plain read irq", irq, 1);
        wr(CTRL, 8'h06);
        wr(CTRL, 8'h09);
        rd(CTRL, rv);
        check("R9 cancelled ack value", rv, 0);
        check("R9 cancelled ack irq", irq, 1);
        ack(rv);
        check("R9 event intact", rv, 8'h33);

        // R12 acknowledge meets new event
        evt(8'h44);
        wr(CTRL, 8'h06);
        @(negedge clk);
        host_addr = CTRL; host_rd_en = 1'b1;
        evt_valid = 1'b1; evt_code = 8'h55;
        @(negedge clk);
        host_rd_en = 1'b0; evt_valid = 1'b0;
        check("R12 old head", host_rdata, 8'h44);
        check("R12 irq kept", irq, 1);
        ack(rv);
        check("R12 new event", rv, 8'h55);

        // R10 clear wipes everything
        evt(8'h61);
        evt(8'h62);
        evt(8'h63);
        check("R10 precondition ovf", evt_overflow, 1);
        clr();
        check("R10 irq dropped", irq, 0);
        check("R10 ovf dropped", evt_overflow, 0);
        evt(8'h64);
        check("R10 deaf after clear", irq, 0);
        ack(rv);
        check("R10 no stale event", rv, 0);
        evt(8'h65);
        check("R10 still unarmed", irq, 0);
        arm();
        ack(rv);
        evt(8'h66);
        check("R10 rearmed", irq, 1);
        ack(rv);
        check("R10 rearmed code", rv, 8'h66);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule